// File: doc/BRIEF.md
# Mode-Aware Bidirectional GPIO Port

This block controls one 8-bit general-purpose I/O port. A simple synchronous register bus reaches four registers: a write-only direction register, a read/write output data register, a read-only pin-state register and a read/write pull-up enable register. From these registers and an operating-mode input, the block drives a per-pin output enable, a per-pin output value and a per-pin pull-up enable. It also samples the pad inputs through a two-flop synchronizer.

In the register-controlled mode (mode 7), the direction and data registers control the pins. In every other mode the port belongs to an external data bus. The pins then follow a bus output-enable input and a bus data input, and the registers have no effect on the pins. Hardware standby clears all writable registers. Software standby keeps their contents and blocks writes.

Reads are registered: `rd_data` updates on the clock edge that samples `rd_en`. The bus has no back-pressure. A strobe is accepted in the cycle it is presented, and `rd_data` holds its value until the next accepted read.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, the data and pull-up registers read 0x00. In mode 7 after reset, `pin_oe`, `pin_out` and `pin_pu` are all 0.
- R2: A write to 0xFF6C sets the data register and a write to 0xFF73 sets the pull-up register. A read of either address returns the stored value on `rd_data` one clock after `rd_en` is sampled.
- R3: A read of the direction register address 0xFEBC always returns 0xFF, whatever was written there.
- R4: In mode 7, `pin_oe[i]` equals direction bit i and `pin_out[i]` equals data bit i. A direction bit of 1 makes its pin an output.
- R5: In any mode other than 7, every `pin_oe` bit equals `bus_oe` and `pin_out` equals `bus_dout`, whatever the register contents.
- R6: `pin_pu[i]` is 1 only when pull-up bit i is 1, direction bit i is 0 and the mode is 7. A pin never has its output enable and its pull-up active together.
- R7: A read of 0xFF5C returns the pad inputs after two synchronizer flops. A write to 0xFF5C has no effect.
- R8: While `hw_standby` is high, the direction, data and pull-up registers are cleared to 0x00 and writes are ignored.
- R9: While `sw_standby` is high and `hw_standby` is low, all three writable registers keep their contents and writes are ignored.
- R10: A read of an unmapped address returns 0x00, and a write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby: clears the writable registers |
| sw_standby | input | 1 | Software standby: holds the writable registers |
| mode | input | 3 | Operating mode; 7 selects register control |
| addr | input | 16 | Register address (low 16 bits) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| bus_oe | input | 1 | External bus output enable (bus modes) |
| bus_dout | input | 8 | External bus output data (bus modes) |
| pad_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
The direction register cannot be read back, so its contents are hard to observe. The bench exposes them through `pin_oe` in mode 7. To show that a register survives a bus mode or a software standby period, the bench switches back to mode 7 and observes the pins again. Hardware standby clearing is confirmed the same way, and an attempted write during standby is followed by the same pin check. Pin sampling is checked by changing `pad_in` and issuing the read only after the two synchronizer stages have filled.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned NUM_WREGS = 3;

  localparam logic [ADDR_W-1:0] ADDR_DIR  = 16'hFEBC;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 16'hFF6C;
  localparam logic [ADDR_W-1:0] ADDR_PIN  = 16'hFF5C;
  localparam logic [ADDR_W-1:0] ADDR_PULL = 16'hFF73;

  localparam logic [2:0] MODE_REGCTL = 3'd7;

  typedef enum logic [1:0] {
    WREG_DIR  = 2'd0,
    WREG_DATA = 2'd1,
    WREG_PULL = 2'd2
  } wreg_e;

  function automatic logic [ADDR_W-1:0] wreg_addr(input int unsigned idx);
    case (idx)
      0:       return ADDR_DIR;
      1:       return ADDR_DATA;
      default: return ADDR_PULL;
    endcase
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_standby,
  input  logic          sw_standby,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  pull_q
);
  logic [NUM_WREGS-1:0][W-1:0] regs_q;
  logic wr_ok;

  assign wr_ok = wr_en && !hw_standby && !sw_standby;

  for (genvar g = 0; g < NUM_WREGS; g++) begin : g_wreg
    localparam logic [AW-1:0] MY_ADDR = AW'(wreg_addr(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs_q[g] <= '0;
      else if (hw_standby)                 regs_q[g] <= '0;
      else if (wr_ok && addr == MY_ADDR)   regs_q[g] <= wdata;
    end
  end

  assign dir_q  = regs_q[WREG_DIR];
  assign data_q = regs_q[WREG_DATA];
  assign pull_q = regs_q[WREG_PULL];

  // R8
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> (dir_q == '0 && data_q == '0 && pull_q == '0));

  // R9
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_standby && !hw_standby) |=> ($stable(dir_q) && $stable(data_q) && $stable(pull_q)));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_sync
);
  logic [STAGES-1:0][W-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) stage_q[s] <= pad_in;
    end else begin : g_next
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic [2:0]   mode,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] pull_q,
  input  logic         bus_oe,
  input  logic [W-1:0] bus_dout,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_pu
);
  logic reg_ctl;
  assign reg_ctl = (mode == MODE_REGCTL);

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (reg_ctl) begin
        pin_oe[i]  = dir_q[i];
        pin_out[i] = data_q[i];
        pin_pu[i]  = pull_q[i] & ~dir_q[i];
      end else begin
        pin_oe[i]  = bus_oe;
        pin_out[i] = bus_dout[i];
        pin_pu[i]  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_standby,
  input  logic          sw_standby,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic          bus_oe,
  input  logic [W-1:0]  bus_dout,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_pu
);
  logic [W-1:0] dir_q, data_q, pull_q, pin_sync;
  logic [W-1:0] rd_mux;

  gpio_port_regs #(.W(W), .AW(AW)) u_regs (
    .clk, .rst_n, .hw_standby, .sw_standby, .wr_en, .addr, .wdata,
    .dir_q, .data_q, .pull_q
  );

  gpio_pin_sync #(.W(W), .STAGES(2)) u_sync (
    .clk, .pad_in, .pin_sync
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .mode, .dir_q, .data_q, .pull_q, .bus_oe, .bus_dout,
    .pin_oe, .pin_out, .pin_pu
  );

  always_comb begin
    unique case (addr)
      AW'(ADDR_DIR):  rd_mux = '1;
      AW'(ADDR_DATA): rd_mux = data_q;
      AW'(ADDR_PIN):  rd_mux = pin_sync;
      AW'(ADDR_PULL): rd_mux = pull_q;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_en)  rd_data <= rd_mux;
  end

  // R3
  dir_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(ADDR_DIR)) |=> rd_data == '1);

  // R6
  oe_pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_pu) == '0);

  // R6
  pu_off_in_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_REGCTL) |-> pin_pu == '0);

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != AW'(ADDR_DIR) && addr != AW'(ADDR_DATA) &&
     addr != AW'(ADDR_PIN) && addr != AW'(ADDR_PULL)) |=> rd_data == '0);
endmodule

// File: tb/gpio_port_ctl_bench.sv
module gpio_port_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_standby = 1'b0, sw_standby = 1'b0;
  logic [2:0] mode = 3'd7;
  logic [15:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, bus_oe = 1'b0;
  logic [7:0] wdata = '0, bus_dout = '0, pad_in = '0;
  logic [7:0] rd_data, pin_oe, pin_out, pin_pu;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_port_ctl u_gpio_port_ctl (
    .clk, .rst_n, .hw_standby, .sw_standby, .mode, .addr, .wr_en, .wdata,
    .rd_en, .rd_data, .bus_oe, .bus_dout, .pad_in, .pin_oe, .pin_out, .pin_pu
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    check("R1 pu", pin_pu, 8'h00);
    rd(16'hFF6C, v); check("R1 data", v, 8'h00);
    rd(16'hFF73, v); check("R1 pull", v, 8'h00);
  endtask

  task automatic t_regctl();
    logic [7:0] v;
    wr(16'hFEBC, 8'hF0);
    wr(16'hFF6C, 8'hA5);
    wr(16'hFF73, 8'h3C);
    rd(16'hFF6C, v); check("R2 data", v, 8'hA5);
    rd(16'hFF73, v); check("R2 pull", v, 8'h3C);
    rd(16'hFEBC, v); check("R3 dir read", v, 8'hFF);
    check("R4 oe", pin_oe, 8'hF0);
    check("R4 out", pin_out, 8'hA5);
    check("R6 pu", pin_pu, 8'h0C);
  endtask

  task automatic t_bus();
    @(negedge clk); mode = 3'd4; bus_oe = 1'b1; bus_dout = 8'h5A;
    #1;
    check("R5 oe m4", pin_oe, 8'hFF);
    check("R5 out m4", pin_out, 8'h5A);
    check("R6 pu bus", pin_pu, 8'h00);
    mode = 3'd6; bus_oe = 1'b0; bus_dout = 8'h81;
    #1;
    check("R5 oe m6", pin_oe, 8'h00);
    check("R5 out m6", pin_out, 8'h81);
    mode = 3'd7;
    #1;
    check("R4 oe back", pin_oe, 8'hF0);
  endtask

  task automatic t_pins();
    logic [7:0] v;
    @(negedge clk); pad_in = 8'h96;
    @(negedge clk);
    @(negedge clk);
    rd(16'hFF5C, v); check("R7 pin read", v, 8'h96);
    wr(16'hFF5C, 8'h11);
    rd(16'hFF5C, v); check("R7 pin write ignored", v, 8'h96);
    rd(16'hFF6C, v); check("R7 data untouched", v, 8'hA5);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(16'hFF6D, 8'h77);
    rd(16'hFF6D, v); check("R10 unmapped read", v, 8'h00);
    rd(16'hFF6C, v); check("R10 data kept", v, 8'hA5);
    check("R10 oe kept", pin_oe, 8'hF0);
  endtask

  task automatic t_sw_standby();
    logic [7:0] v;
    @(negedge clk); sw_standby = 1'b1;
    wr(16'hFEBC, 8'h0F);
    wr(16'hFF6C, 8'h00);
    @(negedge clk); sw_standby = 1'b0;
    check("R9 dir kept", pin_oe, 8'hF0);
    rd(16'hFF6C, v); check("R9 data kept", v, 8'hA5);
  endtask

  task automatic t_hw_standby();
    logic [7:0] v;
    @(negedge clk); hw_standby = 1'b1;
    wr(16'hFEBC, 8'hFF);
    @(negedge clk); hw_standby = 1'b0;
    check("R8 dir cleared", pin_oe, 8'h00);
    check("R8 out cleared", pin_out, 8'h00);
    rd(16'hFF73, v); check("R8 pull cleared", v, 8'h00);
    rd(16'hFF6C, v); check("R8 data cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regctl();
    t_bus();
    t_pins();
    t_unmapped();
    t_sw_standby();
    t_hw_standby();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule